// File: doc/BRIEF.md
# Serial Peripheral Master with Clock-Phase-Dependent Frame Select

This block is a synchronous serial master in the four-mode style with clock polarity and clock phase. It accepts words on a valid/ready push port into a small transmit queue and shifts each word out MSB first on `mosi`. At the same time it shifts the word returned on `miso` into `rx_data` and marks it with a one-cycle `rx_valid`. The serial clock is derived from the system clock. Its half-period is `HALF_DIV` system cycles, so the divide ratio is always even and at least 2.

The block drives its own active-low frame select, `fsel_n`, which software cannot force. Its behaviour between consecutive words depends on the clock phase. With phase 0 it is pulsed high for one serial clock period between words. With phase 1 it stays low across a whole run of queued words. In every mode it is released one serial clock period after the final bit is captured. A run continues only while the queue already holds the next word at the moment the current word completes.

Top module: `spi_fsel_master`

## Requirements
- R1: While idle, `fsel_n` is 1, `busy` is 0 and `sclk` equals `cfg_cpol`; this is also the state right after reset.
- R2: A frame starts with `fsel_n` falling while `sclk` is at the latched idle level and `mosi` already carries the word's MSB. The first `sclk` edge follows exactly `HALF_DIV` cycles later.
- R3: For a lone word of N bits, `fsel_n` stays low for `HALF_DIV*(2N+1)` cycles with phase 0 and `HALF_DIV*(2N+2)` cycles with phase 1. In both cases it rises one serial clock period after the final capture edge.
- R4: With phase 0 (modes 0 and 2), queued words go out as separate low intervals, each as long as a lone word. They are separated by a high pulse of exactly one serial clock period (`2*HALF_DIV` cycles), and `busy` stays 1 through each pulse.
- R5: With phase 1 (modes 1 and 3), queued words form a single low interval of `HALF_DIV*(2N*W+2)` cycles for W words, with no high pulse in between.
- R6: A run is extended only if the next word is already queued when the current word completes. A word pushed later starts a new frame with its own select assertion.
- R7: The mode is {`cfg_cpol`, `cfg_cpha`}. `sclk` idles at CPOL. Data is sampled on the first edge of each bit with CPHA=0 and on the second edge with CPHA=1, and each word is sent MSB first. The word length is `cfg_wlen`, clamped to 4..`MAX_WORD`.
- R8: Each word yields one single-cycle `rx_valid` pulse. `rx_data` then holds the N bits received MSB first, right-aligned, with the upper bits zero.
- R9: Pushes are accepted in order when `push_valid` and `push_ready` are both 1. `push_ready` is 0 exactly when `FIFO_DEPTH` words are waiting.
- R10: `busy` is 1 from the first select assertion until `fsel_n` returns to idle, and it is 1 whenever `fsel_n` is 0.
- R11: Changes to `cfg_cpol`, `cfg_cpha` and `cfg_wlen` while `busy` is 1 have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Clock polarity (idle level of sclk) |
| cfg_cpha | input | 1 | Clock phase (0: sample on first edge, 1: on second) |
| cfg_wlen | input | $clog2(MAX_WORD+1) | Word length in bits, clamped to 4..MAX_WORD |
| push_data | input | MAX_WORD | Word to transmit, right-aligned |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Queue can accept a word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fsel_n | output | 1 | Active-low frame select |
| rx_data | output | MAX_WORD | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Frame in progress |

## Verification
The hardest situation to reach from the ports is the decision made one half-period after the last clock edge of a word. The same word either chains into the next one or ends the frame, depending only on the queue contents at that instant. The stimulus reaches this point in two ways. Back-to-back pushes fill the queue well before completion, so the chain path is taken. A late push is timed a fixed number of cycles after the `rx_valid` strobe, so it lands just after the decision, and two separate select intervals must appear. Configuration inputs are also toggled in the middle of a chained run to show the latched settings hold.

// File: rtl/spi_fsel_pkg.sv
package spi_fsel_pkg;

   localparam int MIN_WORD = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_TAIL,
      ST_GAP
   } sfs_state_e;

   typedef struct packed {
      logic cpol;
      logic cpha;
   } sfs_mode_t;

endpackage

// File: rtl/sfs_txfifo.sv
module sfs_txfifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] wr_data,
   input  logic         wr_valid,
   output logic         wr_ready,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfs_txfifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          wr_en;

   assign wr_ready = (count != CW'(DEPTH));
   assign empty    = (count == '0);
   assign wr_en    = wr_valid && wr_ready;
   assign rd_data  = mem[rptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr_en) wptr <= wptr + 1'b1;
         if (rd_en) rptr <= rptr + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R9: occupancy never exceeds the depth
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R9: the engine never takes a word from an empty queue
   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);

endmodule

// File: rtl/sfs_halftick.sv
module sfs_halftick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (HALF_DIV < 1) begin : g_bad_div
      $error("sfs_halftick: HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      logic          wrap;
      assign wrap = (cnt == CW'(HALF_DIV - 1));
      assign tick = run && wrap;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt <= '0;
         else if (!run)   cnt <= '0;
         else if (wrap)   cnt <= '0;
         else             cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sfs_engine.sv
module sfs_engine
   import spi_fsel_pkg::*;
#(
   parameter int MAXW = 16,
   parameter int LW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            cfg_cpol,
   input  logic            cfg_cpha,
   input  logic [LW-1:0]   cfg_wlen,
   input  logic            fifo_empty,
   input  logic [MAXW-1:0] fifo_head,
   output logic            pop,
   output logic            run,
   output logic            sclk,
   output logic            mosi,
   input  logic            miso,
   output logic            fsel_n,
   output logic [MAXW-1:0] rx_data,
   output logic            rx_valid,
   output logic            busy
);
   localparam int EW = $clog2(2 * MAXW + 1);

   sfs_state_e      state;
   sfs_mode_t       mode_q;
   logic [LW-1:0]   len_q, len_in, load_len;
   logic [EW-1:0]   ecnt, e_next, two_n, cap_edge;
   logic            gap_q, sclk_q, fsel_q, rx_valid_q;
   logic [MAXW-1:0] tx_sh, rx_sh, rx_next, rx_mask, load_word, rx_data_q;
   logic            do_edge, word_end, is_sample, is_shift, last_sample;
   logic            load_idle, load_chain, load_gap;

   always_comb begin
      if (cfg_wlen < LW'(MIN_WORD))  len_in = LW'(MIN_WORD);
      else if (cfg_wlen > LW'(MAXW)) len_in = LW'(MAXW);
      else                           len_in = cfg_wlen;
   end

   assign two_n     = EW'(len_q) << 1;
   assign e_next    = ecnt + 1'b1;
   assign cap_edge  = mode_q.cpha ? two_n : (two_n - 1'b1);
   assign word_end  = (state == ST_RUN) && tick && (ecnt == two_n);
   assign do_edge   = (state == ST_RUN) && tick && (ecnt != two_n);
   assign is_sample = do_edge && (mode_q.cpha ? !e_next[0] : e_next[0]);
   assign is_shift  = do_edge && (mode_q.cpha ? (e_next[0] && e_next != EW'(1)) : !e_next[0]);
   assign last_sample = is_sample && (e_next == cap_edge);

   assign load_idle  = (state == ST_IDLE) && !fifo_empty;
   assign load_chain = word_end && mode_q.cpha && !fifo_empty;
   assign load_gap   = (state == ST_GAP) && tick && gap_q;
   assign pop        = load_idle || load_chain || load_gap;
   assign load_len   = load_idle ? len_in : len_q;
   assign load_word  = fifo_head << (MAXW - int'(load_len));

   assign rx_next = {rx_sh[MAXW-2:0], miso};
   assign rx_mask = {MAXW{1'b1}} >> (MAXW - int'(len_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         mode_q     <= '0;
         len_q      <= LW'(MIN_WORD);
         ecnt       <= '0;
         gap_q      <= 1'b0;
         sclk_q     <= 1'b0;
         fsel_q     <= 1'b1;
         tx_sh      <= '0;
         rx_sh      <= '0;
         rx_data_q  <= '0;
         rx_valid_q <= 1'b0;
      end else begin
         rx_valid_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               sclk_q <= cfg_cpol;
               if (load_idle) begin
                  mode_q <= '{cpol: cfg_cpol, cpha: cfg_cpha};
                  len_q  <= len_in;
                  tx_sh  <= load_word;
                  ecnt   <= '0;
                  fsel_q <= 1'b0;
                  state  <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (do_edge) begin
                  sclk_q <= ~sclk_q;
                  ecnt   <= e_next;
                  if (is_shift)  tx_sh <= tx_sh << 1;
                  if (is_sample) rx_sh <= rx_next;
                  if (last_sample) begin
                     rx_data_q  <= rx_next & rx_mask;
                     rx_valid_q <= 1'b1;
                  end
               end else if (word_end) begin
                  if (!mode_q.cpha) begin
                     fsel_q <= 1'b1;
                     gap_q  <= 1'b0;
                     state  <= fifo_empty ? ST_IDLE : ST_GAP;
                  end else if (load_chain) begin
                     tx_sh  <= load_word;
                     sclk_q <= ~sclk_q;
                     ecnt   <= EW'(1);
                  end else begin
                     state <= ST_TAIL;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  fsel_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  gap_q <= 1'b1;
                  if (load_gap) begin
                     tx_sh  <= load_word;
                     ecnt   <= '0;
                     fsel_q <= 1'b0;
                     state  <= ST_RUN;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign run      = busy;
   assign sclk     = (state == ST_IDLE) ? cfg_cpol : sclk_q;
   assign mosi     = tx_sh[MAXW-1];
   assign fsel_n   = fsel_q;
   assign rx_data  = rx_data_q;
   assign rx_valid = rx_valid_q;

   // R1: an idle block keeps the select high
   a_r1_idle_select: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> fsel_n);
   // R2: a frame opens with sclk at its latched idle level
   a_r2_start_level: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fsel_n) |-> (sclk == mode_q.cpol));
   // R3: sclk only moves inside an asserted select
   a_r3_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (sclk != $past(sclk))) |-> !fsel_n);
   // R4: a release between phase-0 words lasts more than one cycle
   a_r4_gap_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fsel_n) && busy) |=> fsel_n);
   // R5: a phase-1 word with a successor queued keeps the select low
   a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (word_end && mode_q.cpha && !fifo_empty) |=> !fsel_n);
   // R8: the receive strobe is a single-cycle pulse
   a_r8_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R10: select asserted implies busy
   a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
      !fsel_n |-> busy);
   // R11: latched configuration holds for the whole frame
   a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(mode_q) && $stable(len_q)));

endmodule

// File: rtl/spi_fsel_master.sv
module spi_fsel_master
   import spi_fsel_pkg::*;
#(
   parameter int MAX_WORD   = 16,
   parameter int FIFO_DEPTH = 4,
   parameter int HALF_DIV   = 2,
   localparam int LW        = $clog2(MAX_WORD + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_cpol,
   input  logic                cfg_cpha,
   input  logic [LW-1:0]       cfg_wlen,
   input  logic [MAX_WORD-1:0] push_data,
   input  logic                push_valid,
   output logic                push_ready,
   output logic                sclk,
   output logic                mosi,
   input  logic                miso,
   output logic                fsel_n,
   output logic [MAX_WORD-1:0] rx_data,
   output logic                rx_valid,
   output logic                busy
);
   if (MAX_WORD < MIN_WORD || MAX_WORD > 32) begin : g_bad_word
      $error("spi_fsel_master: MAX_WORD must lie in 4..32");
   end

   logic                fifo_empty, pop, run, tick;
   logic [MAX_WORD-1:0] fifo_head;

   sfs_txfifo #(.W(MAX_WORD), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (push_data),
      .wr_valid (push_valid),
      .wr_ready (push_ready),
      .rd_en    (pop),
      .rd_data  (fifo_head),
      .empty    (fifo_empty)
   );

   sfs_halftick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   sfs_engine #(.MAXW(MAX_WORD), .LW(LW)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cfg_cpol   (cfg_cpol),
      .cfg_cpha   (cfg_cpha),
      .cfg_wlen   (cfg_wlen),
      .fifo_empty (fifo_empty),
      .fifo_head  (fifo_head),
      .pop        (pop),
      .run        (run),
      .sclk       (sclk),
      .mosi       (mosi),
      .miso       (miso),
      .fsel_n     (fsel_n),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .busy       (busy)
   );

endmodule

// File: tb/spi_fsel_master_tb.sv
module spi_fsel_master_tb;
   localparam int CLK_PERIOD = 10;
   localparam int H     = 2;
   localparam int MW    = 16;
   localparam int DEPTH = 4;
   localparam int LW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [LW-1:0] cfg_wlen = 5'd8;
   logic [MW-1:0] push_data = '0;
   logic          push_valid = 1'b0;
   logic          push_ready, sclk, mosi, miso, fsel_n, rx_valid, busy;
   logic [MW-1:0] rx_data;

   int n_checks = 0, n_err = 0;

   // monitor state
   bit mon_en = 0;
   int t_len = 8;
   bit t_cpol = 0, t_cpha = 0;
   int nlow, ngap, nfall, nrx, sl_idx, sl_k, lowcnt, highcnt, dcnt, busy_bad;
   bit waiting;
   int lows[8], gaps[8], dlys[8];
   logic fmosi[8], fsclk[8], rbusy[8];
   logic [MW-1:0] rx_got[8], sl_got[8], pats[8], txw[8];
   logic [MW-1:0] sl_word;
   logic prev_f = 1'b1, prev_s = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_fsel_master #(.MAX_WORD(MW), .FIFO_DEPTH(DEPTH), .HALF_DIV(H)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_wlen(cfg_wlen), .push_data(push_data), .push_valid(push_valid),
      .push_ready(push_ready), .sclk(sclk), .mosi(mosi), .miso(miso),
      .fsel_n(fsel_n), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy)
   );

   // slave returns pats[word] MSB first, bit chosen by captures so far
   assign miso = (mon_en && sl_k < t_len && sl_idx < 8) ? pats[sl_idx][t_len-1-sl_k] : 1'b0;

   always @(negedge clk) begin
      if (mon_en) begin
         if (prev_f && !fsel_n) begin
            if (nlow > 0 && ngap < 8) begin gaps[ngap] = highcnt; ngap++; end
            if (nfall < 8) begin fmosi[nfall] = mosi; fsclk[nfall] = sclk; end
            nfall++;
            lowcnt = 0; waiting = 1; dcnt = 0;
         end else if (waiting) begin
            dcnt++;
            if (sclk != prev_s) begin
               if (nfall - 1 < 8) dlys[nfall-1] = dcnt;
               waiting = 0;
            end
         end
         if (!prev_f && fsel_n) begin
            if (nlow < 8) begin lows[nlow] = lowcnt; rbusy[nlow] = busy; end
            nlow++;
            highcnt = 0;
         end
         if (!fsel_n) lowcnt++; else highcnt++;
         if (!fsel_n && !busy) busy_bad++;
         if (!fsel_n && sclk != prev_s &&
             ((t_cpha == 0) ? (sclk != t_cpol) : (sclk == t_cpol))) begin
            sl_word = (sl_word << 1) | MW'(mosi);
            sl_k++;
            if (sl_k == t_len) begin
               if (sl_idx < 8) sl_got[sl_idx] = sl_word;
               sl_idx++; sl_k = 0; sl_word = '0;
            end
         end
         if (rx_valid) begin
            if (nrx < 8) rx_got[nrx] = rx_data;
            nrx++;
         end
      end
      prev_f = fsel_n;
      prev_s = sclk;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic mon_clear();
      nlow = 0; ngap = 0; nfall = 0; nrx = 0; sl_idx = 0; sl_k = 0;
      lowcnt = 0; highcnt = 0; dcnt = 0; waiting = 0; busy_bad = 0;
      sl_word = '0;
   endtask

   task automatic push(input logic [MW-1:0] w);
      @(negedge clk);
      push_data  = w;
      push_valid = 1'b1;
      @(posedge clk);
      #1 push_valid = 1'b0;
   endtask

   // kind: 0 normal, 1 late second push, 2 configuration disturbed mid-frame
   task automatic run_case(input int cpol, input int cpha, input int len, input int nw, input int kind);
      logic [MW-1:0] mask;
      int exp_nlow, exp_len, idle;
      mask = MW'((32'h1 << len) - 1);
      @(negedge clk);
      cfg_cpol = cpol[0]; cfg_cpha = cpha[0]; cfg_wlen = LW'(len);
      t_cpol = cpol[0]; t_cpha = cpha[0]; t_len = len;
      mon_clear();
      for (int i = 0; i < nw; i++) begin
         txw[i]  = MW'(32'hB35D * (i + 3) + len * 131 + cpol * 40 + cpha * 17) & mask;
         pats[i] = (MW'(txw[i] * 3 + 5) ^ 16'h9C35) & mask;
      end
      mon_en = 1;
      if (kind == 1) begin
         push(txw[0]);
         do @(negedge clk); while (!rx_valid);
         repeat (2) @(posedge clk);
         push(txw[1]);
      end else begin
         for (int i = 0; i < nw; i++) push(txw[i]);
         @(negedge clk);
         chk(push_ready == ((nw - 1) < DEPTH), "R9 push_ready vs queue fill", push_ready, (nw - 1) < DEPTH);
      end
      if (kind == 2) begin
         repeat (6) @(negedge clk);
         cfg_wlen = LW'(12); cfg_cpha = ~cfg_cpha; cfg_cpol = ~cfg_cpol;
      end
      idle = 0;
      while (idle < 6) begin
         @(negedge clk);
         idle = busy ? 0 : idle + 1;
      end
      cfg_cpol = cpol[0]; cfg_cpha = cpha[0]; cfg_wlen = LW'(len);
      @(negedge clk);
      mon_en = 0;
      // R1 idle state after the frame
      chk(fsel_n == 1'b1, "R1 idle fsel_n", fsel_n, 1);
      chk(busy == 1'b0, "R1 idle busy", busy, 0);
      chk(sclk == cpol[0], "R1 idle sclk level", sclk, cpol);
      chk(busy_bad == 0, "R10 busy while select low", busy_bad, 0);
      if (cpha == 1 && kind != 1) begin
         exp_nlow = 1; exp_len = H * (2 * len * nw + 2);
      end else begin
         exp_nlow = nw; exp_len = H * (2 * len + 1 + cpha);
      end
      chk(nlow == exp_nlow, (kind == 1) ? "R6 late push gives new frame" : "R5/R4 select interval count", nlow, exp_nlow);
      for (int i = 0; i < exp_nlow && i < 8; i++)
         chk(lows[i] == exp_len, (nw == 1) ? "R3 lone word select length" : "R4/R5 select interval length", lows[i], exp_len);
      if (cpha == 0 && kind != 1) begin
         chk(ngap == nw - 1, "R4 number of high pulses", ngap, nw - 1);
         for (int i = 0; i < ngap && i < 8; i++)
            chk(gaps[i] == 2 * H, "R4 high pulse is one sclk period", gaps[i], 2 * H);
         for (int i = 0; i < nlow && i < 8; i++)
            chk(rbusy[i] == (i < nw - 1), "R10 busy across release", rbusy[i], i < nw - 1);
      end else if (kind != 1) begin
         chk(ngap == 0, "R5 no pulse in phase-1 run", ngap, 0);
      end
      chk(dlys[0] == H, "R2 half period before first edge", dlys[0], H);
      chk(fmosi[0] == txw[0][len-1], "R2 MSB on mosi at select fall", fmosi[0], txw[0][len-1]);
      chk(fsclk[0] == cpol[0], "R2 sclk idle level at start", fsclk[0], cpol);
      chk(sl_idx == nw, "R7 words seen by slave", sl_idx, nw);
      for (int i = 0; i < nw && i < 8; i++)
         chk(sl_got[i] == txw[i], (kind == 2) ? "R11 frame unaffected by cfg change" : "R7 mosi word MSB first", sl_got[i], txw[i]);
      chk(nrx == nw, "R8 one rx_valid per word", nrx, nw);
      for (int i = 0; i < nw && i < 8; i++)
         chk(rx_got[i] == pats[i], "R8 received word", rx_got[i], pats[i]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      int lens[4];
      lens[0] = 4; lens[1] = 7; lens[2] = 12; lens[3] = 16;
      cfg_cpol = 1'b1;
      repeat (5) @(negedge clk);
      // R1 / R9 reset state
      chk(fsel_n == 1'b1, "R1 reset fsel_n", fsel_n, 1);
      chk(busy == 1'b0, "R1 reset busy", busy, 0);
      chk(sclk == 1'b1, "R1 reset sclk follows cpol", sclk, 1);
      chk(push_ready == 1'b1, "R9 reset push_ready", push_ready, 1);
      rst_n = 1'b1;
      cfg_cpol = 1'b0;
      repeat (3) @(negedge clk);
      for (int m = 0; m < 4; m++) begin
         for (int l = 0; l < 4; l++) begin
            run_case(m >> 1, m & 1, lens[l], 1, 0);
            run_case(m >> 1, m & 1, lens[l], 3, 0);
         end
      end
      run_case(0, 1, 8, 2, 1);   // R6 late push
      run_case(0, 1, 8, 3, 2);   // R11 cfg change mid-frame
      run_case(1, 0, 6, 3, 2);   // R11 phase-0 variant
      run_case(1, 1, 16, 5, 0);  // R9 queue fills
      run_case(0, 0, 5, 5, 0);   // R9 queue fills, phase 0
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule